// File: doc/BRIEF.md
# Table Access Protection Unit

This unit sits in the path between a small processor's table read/write engine and its flash program memory. For every table access it decides whether the access may go ahead, using the table pointer address, the program counter of the instruction that issued it, and two protection bits held for each region of program memory. Refused writes never reach the memory and raise a one-cycle violation pulse. Refused reads return all zeros in place of memory data.

The protected space is five regions: a boot region, region 0, at 000000h–0007FFh, then user regions 1 to 4 at 000800h–001FFFh, 002000h–003FFFh, 004000h–005FFFh and 006000h–007FFFh. Each region has a write-protect bit and a read-protect bit, active low. A read-protected region stays readable by code that runs inside it. The protection bits live in a configuration space starting at `CFG_BASE`. Table writes can only clear them. Only an erase from the external programming port sets them again, either for one region or for the whole chip.

Top module: `tblGuard`

## Requirements
- R1: Addresses below 0800h belong to region 0 (boot). 0800h–1FFFh, 2000h–3FFFh, 4000h–5FFFh and 6000h–7FFFh belong to regions 1, 2, 3 and 4. Bit i of each protection word controls region i.
- R2: A table write to a region whose write-protect bit is 0 is refused wherever the program counter lies. For a refused write, `memWrEn` stays low and `wrViolation` is high for exactly the one cycle that holds the result. An allowed write raises `memWrEn` with `memWrAddr`/`memWrData` equal to the request.
- R3: A table read of a region is allowed when that region's read-protect bit is 1, or when the program counter lies in the same region. The returned data is `memRdData`.
- R4: A table read of a region whose read-protect bit is 0, issued with the program counter outside that region, returns all zeros.
- R5: Addresses from 8000h up to `CFG_BASE`-1 are not checked: table reads return memory data and table writes always reach memory.
- R6: A table write to `CFG_BASE`+0 updates the write-protect word and one to `CFG_BASE`+1 updates the read-protect word. Both updates are a bitwise AND with `wrData`, so no bit ever goes from 0 to 1. Such a write is neither refused nor passed to memory.
- R7: A table read of `CFG_BASE`+0 or `CFG_BASE`+1 returns the write-protect or read-protect word, zero-extended. Any other configuration address reads as zero.
- R8: A region erase (`eraseRegion` with `eraseIdx` = i) sets both protection bits of region i to 1 and leaves the other regions' bits unchanged.
- R9: A chip erase sets every protection bit to 1. `eraseDone` is high in the cycle that follows the one in which `eraseChip` was sampled.
- R10: All results are registered one cycle after the request. `rdValid` is high for one cycle per table read. With no request, `rdValid`, `memWrEn` and `wrViolation` are low.
- R11: After reset every protection bit is 1, and `rdValid`, `memWrEn`, `wrViolation` and `eraseDone` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tblAddr | input | ADDR_W | Table pointer address |
| pc | input | ADDR_W | Address of the executing table instruction |
| rdReq | input | 1 | Table read request |
| wrReq | input | 1 | Table write request (takes precedence over a read) |
| wrData | input | DATA_W | Table write data |
| memRdData | input | DATA_W | Data the flash returns for `tblAddr` |
| eraseChip | input | 1 | Full-chip erase from the programming port |
| eraseRegion | input | 1 | Single-region erase from the programming port |
| eraseIdx | input | IDX_W | Region selected by `eraseRegion` |
| rdData | output | DATA_W | Registered table read result |
| rdValid | output | 1 | `rdData` holds a read result |
| memWrEn | output | 1 | Write strobe to flash |
| memWrAddr | output | ADDR_W | Write address to flash |
| memWrData | output | DATA_W | Write data to flash |
| wrViolation | output | 1 | Table write refused |
| eraseDone | output | 1 | Chip erase completed |

## Verification
Every read, write and violation result shows up on the outputs after exactly one rising edge. The bench drives each request on a falling edge and compares the outputs one time unit after the next rising edge. After that it spends one idle cycle to confirm that `rdValid` and `wrViolation` have fallen back. Protection bit updates from configuration writes and erases take effect at the same edge. They are observed through configuration reads issued in the following cycles, and `eraseDone` is compared in the cycle right after the erase was sampled.

// File: rtl/tblGuardPkg.sv
package tblGuardPkg;
  // Strobes from the decision logic to the datapath, one per access outcome.
  typedef struct packed {
    logic rdAct;      // a table read is being answered
    logic rdPass;     // read returns memory data
    logic rdCfgW;     // read returns the write-protect word
    logic rdCfgR;     // read returns the read-protect word
    logic memWr;      // write forwarded to flash
    logic violation;  // write refused
    logic cfgWrW;     // AND-update of the write-protect word
    logic cfgWrR;     // AND-update of the read-protect word
  } strobe_t;
endpackage

// File: rtl/tblGuardCtrl.sv
module tblGuardCtrl
  import tblGuardPkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int NUM_USER  = 4,
  parameter int BOOT_SIZE = 'h800,
  parameter int USER_LOG2 = 13,
  parameter logic [ADDR_W-1:0] CFG_BASE = 22'h300000
) (
  input  logic [ADDR_W-1:0]   tblAddr,
  input  logic [ADDR_W-1:0]   pc,
  input  logic                rdReq,
  input  logic                wrReq,
  input  logic [NUM_USER:0]   wrtBits,
  input  logic [NUM_USER:0]   rdBits,
  output strobe_t             stb
);
  localparam int NREG  = NUM_USER + 1;
  localparam int IDX_W = $clog2(NREG);
  localparam logic [ADDR_W-1:0] PROT_END = ADDR_W'(NUM_USER) << USER_LOG2;

  logic              addrCov, pcCov, addrCfg, sameReg, rdOk, wrOk;
  logic [IDX_W-1:0]  addrIdx, pcIdx;
  logic [ADDR_W-1:0] cfgOff;

  function automatic logic [IDX_W-1:0] regionIdx(input logic [ADDR_W-1:0] a);
    if (a < ADDR_W'(BOOT_SIZE)) return '0;
    return IDX_W'((a >> USER_LOG2) + ADDR_W'(1));
  endfunction

  always_comb begin
    addrCov = tblAddr < PROT_END;
    pcCov   = pc < PROT_END;
    addrIdx = regionIdx(tblAddr);
    pcIdx   = regionIdx(pc);
    addrCfg = tblAddr >= CFG_BASE;
    cfgOff  = tblAddr - CFG_BASE;
    sameReg = pcCov && (pcIdx == addrIdx);
    rdOk    = !addrCov || rdBits[addrIdx] || sameReg;
    wrOk    = !addrCov || wrtBits[addrIdx];

    stb           = '0;
    stb.rdAct     = rdReq && !wrReq;
    stb.rdPass    = stb.rdAct && !addrCfg && rdOk;
    stb.rdCfgW    = stb.rdAct && addrCfg && (cfgOff == '0);
    stb.rdCfgR    = stb.rdAct && addrCfg && (cfgOff == ADDR_W'(1));
    stb.violation = wrReq && !addrCfg && !wrOk;
    stb.memWr     = wrReq && !addrCfg && wrOk;
    stb.cfgWrW    = wrReq && addrCfg && (cfgOff == '0);
    stb.cfgWrR    = wrReq && addrCfg && (cfgOff == ADDR_W'(1));
  end
endmodule

// File: rtl/tblGuardData.sv
module tblGuardData
  import tblGuardPkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int DATA_W   = 8,
  parameter int NUM_USER = 4,
  parameter int IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] tblAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              eraseChip,
  input  logic              eraseRegion,
  input  logic [IDX_W-1:0]  eraseIdx,
  output logic [NUM_USER:0] wrtBits,
  output logic [NUM_USER:0] rdBits,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              wrViolation,
  output logic              eraseDone
);
  localparam int NREG = NUM_USER + 1;

  logic [NREG-1:0]   wrtNext, rdNext, eraseMask;
  logic [DATA_W-1:0] rdNextData;

  // One erase-select bit per region.
  for (genvar g = 0; g < NREG; g++) begin : g_erase
    assign eraseMask[g] = eraseChip || (eraseRegion && (eraseIdx == IDX_W'(g)));
  end

  always_comb begin
    wrtNext = (stb.cfgWrW ? (wrtBits & wrData[NREG-1:0]) : wrtBits) | eraseMask;
    rdNext  = (stb.cfgWrR ? (rdBits  & wrData[NREG-1:0]) : rdBits)  | eraseMask;
    if (stb.rdPass)      rdNextData = memRdData;
    else if (stb.rdCfgW) rdNextData = DATA_W'(wrtBits);
    else if (stb.rdCfgR) rdNextData = DATA_W'(rdBits);
    else                 rdNextData = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrtBits     <= '1;
      rdBits      <= '1;
      rdData      <= '0;
      rdValid     <= 1'b0;
      memWrEn     <= 1'b0;
      memWrAddr   <= '0;
      memWrData   <= '0;
      wrViolation <= 1'b0;
      eraseDone   <= 1'b0;
    end else begin
      wrtBits     <= wrtNext;
      rdBits      <= rdNext;
      rdData      <= stb.rdAct ? rdNextData : '0;
      rdValid     <= stb.rdAct;
      memWrEn     <= stb.memWr;
      memWrAddr   <= stb.memWr ? tblAddr : memWrAddr;
      memWrData   <= stb.memWr ? wrData : memWrData;
      wrViolation <= stb.violation;
      eraseDone   <= eraseChip;
    end
  end
endmodule

// File: rtl/tblGuard.sv
module tblGuard
  import tblGuardPkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 8,
  parameter int NUM_USER  = 4,
  parameter int BOOT_SIZE = 'h800,
  parameter int USER_LOG2 = 13,
  parameter logic [ADDR_W-1:0] CFG_BASE = 22'h300000,
  parameter int IDX_W     = $clog2(NUM_USER + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] tblAddr,
  input  logic [ADDR_W-1:0] pc,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              eraseChip,
  input  logic              eraseRegion,
  input  logic [IDX_W-1:0]  eraseIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              wrViolation,
  output logic              eraseDone
);
  strobe_t             stb;
  logic [NUM_USER:0]   wrtBits, rdBits;

  tblGuardCtrl #(
    .ADDR_W(ADDR_W), .NUM_USER(NUM_USER), .BOOT_SIZE(BOOT_SIZE),
    .USER_LOG2(USER_LOG2), .CFG_BASE(CFG_BASE)
  ) u_ctrl (
    .tblAddr(tblAddr), .pc(pc), .rdReq(rdReq), .wrReq(wrReq),
    .wrtBits(wrtBits), .rdBits(rdBits), .stb(stb)
  );

  tblGuardData #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_USER(NUM_USER), .IDX_W(IDX_W)
  ) u_data (
    .clk(clk), .rst(rst), .stb(stb), .tblAddr(tblAddr), .wrData(wrData),
    .memRdData(memRdData), .eraseChip(eraseChip), .eraseRegion(eraseRegion),
    .eraseIdx(eraseIdx), .wrtBits(wrtBits), .rdBits(rdBits),
    .rdData(rdData), .rdValid(rdValid), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData),
    .wrViolation(wrViolation), .eraseDone(eraseDone)
  );
endmodule

// File: rtl/tblGuardChk.sv
module tblGuardChk #(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 8,
  parameter int NUM_USER  = 4,
  parameter int BOOT_SIZE = 'h800,
  parameter int USER_LOG2 = 13,
  parameter int IDX_W     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] tblAddr,
  input logic [ADDR_W-1:0] pc,
  input logic              rdReq,
  input logic              wrReq,
  input logic              eraseChip,
  input logic              eraseRegion,
  input logic [IDX_W-1:0]  eraseIdx,
  input logic [NUM_USER:0] wrtBits,
  input logic [NUM_USER:0] rdBits,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic              memWrEn,
  input logic              wrViolation,
  input logic              eraseDone
);
  localparam int NREG = NUM_USER + 1;
  localparam logic [ADDR_W-1:0] TOPA = ADDR_W'(NUM_USER) << USER_LOG2;

  logic             aIn, pIn, rdDenied, wrDenied;
  logic [IDX_W-1:0] aReg, pReg;

  always_comb begin
    aIn  = tblAddr < TOPA;
    pIn  = pc < TOPA;
    aReg = (tblAddr < ADDR_W'(BOOT_SIZE)) ? '0 : IDX_W'(tblAddr >> USER_LOG2) + IDX_W'(1);
    pReg = (pc < ADDR_W'(BOOT_SIZE)) ? '0 : IDX_W'(pc >> USER_LOG2) + IDX_W'(1);
    wrDenied = wrReq && aIn && !wrtBits[aReg];
    rdDenied = rdReq && !wrReq && aIn && !rdBits[aReg] && !(pIn && pReg == aReg);
  end

  p_wr_refused_r2: assert property (@(posedge clk) disable iff (rst)
    wrDenied |=> (wrViolation && !memWrEn));

  p_viol_excl_r2: assert property (@(posedge clk) disable iff (rst)
    wrViolation |-> !memWrEn);

  p_rd_zero_r4: assert property (@(posedge clk) disable iff (rst)
    rdDenied |=> (rdValid && rdData == '0));

  p_one_way_r6: assert property (@(posedge clk) disable iff (rst)
    (!eraseChip && !eraseRegion) |=>
      (((wrtBits & ~$past(wrtBits)) == '0) && ((rdBits & ~$past(rdBits)) == '0)));

  p_region_erase_r8: assert property (@(posedge clk) disable iff (rst)
    (eraseRegion && eraseIdx < IDX_W'(NREG)) |=>
      (wrtBits[$past(eraseIdx)] && rdBits[$past(eraseIdx)]));

  p_chip_erase_r9: assert property (@(posedge clk) disable iff (rst)
    eraseChip |=> (eraseDone && (&wrtBits) && (&rdBits)));

  p_rd_valid_r10: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> $past(rdReq && !wrReq));
endmodule

bind tblGuard tblGuardChk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_USER(NUM_USER),
  .BOOT_SIZE(BOOT_SIZE), .USER_LOG2(USER_LOG2), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .tblAddr(tblAddr), .pc(pc), .rdReq(rdReq),
  .wrReq(wrReq), .eraseChip(eraseChip), .eraseRegion(eraseRegion),
  .eraseIdx(eraseIdx), .wrtBits(wrtBits), .rdBits(rdBits),
  .rdData(rdData), .rdValid(rdValid), .memWrEn(memWrEn),
  .wrViolation(wrViolation), .eraseDone(eraseDone)
);

// File: tb/test_tblGuard.sv
module test_tblGuard;
  localparam int AW = 22;
  localparam int DW = 8;
  localparam logic [AW-1:0] CFG = 22'h300000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] tblAddr = '0, pc = '0;
  logic          rdReq = 1'b0, wrReq = 1'b0;
  logic [DW-1:0] wrData = '0, memRdData;
  logic          eraseChip = 1'b0, eraseRegion = 1'b0;
  logic [2:0]    eraseIdx = '0;
  logic [DW-1:0] rdData, memWrData;
  logic [AW-1:0] memWrAddr;
  logic          rdValid, memWrEn, wrViolation, eraseDone;

  int checks = 0, errors = 0;
  logic [4:0] mW = 5'h1F, mR = 5'h1F;

  always #5 clk = ~clk;
  assign memRdData = tblAddr[7:0] ^ tblAddr[15:8] ^ 8'hA5;

  tblGuard i_tblGuard (
    .clk(clk), .rst(rst), .tblAddr(tblAddr), .pc(pc), .rdReq(rdReq),
    .wrReq(wrReq), .wrData(wrData), .memRdData(memRdData),
    .eraseChip(eraseChip), .eraseRegion(eraseRegion), .eraseIdx(eraseIdx),
    .rdData(rdData), .rdValid(rdValid), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData),
    .wrViolation(wrViolation), .eraseDone(eraseDone)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Region number from the address map of R1, -1 when unchecked.
  function automatic int regOf(input logic [AW-1:0] a);
    if (a < 22'h000800) return 0;
    if (a < 22'h002000) return 1;
    if (a < 22'h004000) return 2;
    if (a < 22'h006000) return 3;
    if (a < 22'h008000) return 4;
    return -1;
  endfunction

  function automatic logic [7:0] expRead(input logic [AW-1:0] a, input logic [AW-1:0] p);
    int r;
    if (a >= CFG) begin
      if (a == CFG)      return {3'b0, mW};
      if (a == CFG + 1)  return {3'b0, mR};
      return 8'h00;
    end
    r = regOf(a);
    if (r < 0 || mR[r] || regOf(p) == r) return a[7:0] ^ a[15:8] ^ 8'hA5;
    return 8'h00;
  endfunction

  task automatic idleCheck(input string req);
    @(negedge clk);
    rdReq = 0; wrReq = 0; eraseChip = 0; eraseRegion = 0;
    @(posedge clk); #1;
    chk(req, {rdValid, memWrEn, wrViolation}, 3'b000);
  endtask

  task automatic doRead(input logic [AW-1:0] a, input logic [AW-1:0] p, input string req);
    logic [7:0] e;
    @(negedge clk);
    tblAddr = a; pc = p; rdReq = 1;
    e = expRead(a, p);
    @(posedge clk); #1;
    chk(req, {rdValid, rdData}, {1'b1, e});
    idleCheck("R10");
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [AW-1:0] p,
                         input logic [7:0] d, input string req);
    int r;
    logic refuse, pass;
    @(negedge clk);
    tblAddr = a; pc = p; wrData = d; wrReq = 1;
    r = regOf(a);
    refuse = (a < CFG) && (r >= 0) && !mW[r];
    pass   = (a < CFG) && !refuse;
    @(posedge clk); #1;
    chk(req, {memWrEn, wrViolation}, {pass, refuse});
    if (pass) chk(req, {memWrAddr, memWrData}, {a, d});
    if (a == CFG)     mW = mW & d[4:0];
    if (a == CFG + 1) mR = mR & d[4:0];
    idleCheck("R2 pulse");
  endtask

  task automatic doErase(input logic chip, input logic [2:0] idx);
    @(negedge clk);
    eraseChip = chip; eraseRegion = !chip; eraseIdx = idx;
    @(posedge clk); #1;
    chk("R9 done", eraseDone, chip);
    if (chip) begin mW = 5'h1F; mR = 5'h1F; end
    else if (idx < 5) begin mW[idx] = 1; mR[idx] = 1; end
    idleCheck("R10");
  endtask

  function automatic logic [AW-1:0] pickAddr();
    int k = $urandom % 8;
    case (k)
      0: return AW'($urandom % 22'h800);
      1: return 22'h000800 + AW'($urandom % 22'h1800);
      2, 3, 4: return AW'((k - 1) * 22'h2000) + AW'($urandom % 22'h2000);
      5: return 22'h008000 + AW'($urandom % 22'h4000);
      default: return CFG + AW'($urandom % 3);
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    chk("R11 reset outputs", {rdValid, memWrEn, wrViolation, eraseDone}, 4'b0);
    doRead(CFG, 22'h100, "R11 wrt bits");
    doRead(CFG + 1, 22'h100, "R11 rd bits");

    // R6: clear region 1 write-protect, then try to set it back.
    doWrite(CFG, 22'h100, 8'hFD, "R6 cfg write");
    doRead(CFG, 22'h100, "R6 readback");
    doWrite(CFG, 22'h100, 8'hFF, "R6 one-way");
    doRead(CFG, 22'h100, "R6 one-way readback");
    // R2: refused from inside and outside the region.
    doWrite(22'h0008FF, 22'h001FFE, 8'h3C, "R2 inside pc");
    doWrite(22'h0008FF, 22'h005FFE, 8'h3C, "R2 outside pc");
    doWrite(22'h002100, 22'h000200, 8'h77, "R2 allowed");
    // R1 boundaries: 1FFFh is region 1, 2000h region 2.
    doWrite(22'h001FFF, 22'h000200, 8'h11, "R1 top of region 1");
    doWrite(22'h002000, 22'h000200, 8'h12, "R1 base of region 2");
    doWrite(22'h0007FF, 22'h000200, 8'h13, "R1 top of boot");
    // R3/R4: read-protect region 3.
    doWrite(CFG + 1, 22'h100, 8'hF7, "R6 rd cfg");
    doRead(22'h004010, 22'h004500, "R3 same region");
    doRead(22'h004010, 22'h000100, "R4 outside");
    doRead(22'h005FFF, 22'h006000, "R4 neighbour");
    doRead(22'h002010, 22'h000100, "R3 unprotected");
    // R5: unchecked space.
    doRead(22'h009000, 22'h004100, "R5 read");
    doWrite(22'h009000, 22'h004100, 8'h5A, "R5 write");
    // R7.
    doRead(CFG + 2, 22'h100, "R7 other cfg");
    doRead(CFG + 1, 22'h100, "R7 rd word");
    // R8 / R9.
    doErase(1'b0, 3'd1);
    doRead(CFG, 22'h100, "R8 region erase wrt");
    doRead(CFG + 1, 22'h100, "R8 other region kept");
    doErase(1'b1, 3'd0);
    doRead(CFG, 22'h100, "R9 chip erase wrt");
    doRead(CFG + 1, 22'h100, "R9 chip erase rd");

    // Constrained random mix.
    for (int i = 0; i < 800; i++) begin
      int op = $urandom % 20;
      logic [AW-1:0] a = pickAddr();
      logic [AW-1:0] p = AW'($urandom % 22'h9000);
      if (op < 9)       doRead(a, p, "R3/R4 random read");
      else if (op < 17) doWrite(a, p, 8'($urandom | 32'h10), "R2 random write");
      else if (op < 19) doErase(1'b0, 3'($urandom % 5));
      else              doErase(1'b1, 3'd0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule